// File: doc/BRIEF.md
# AXI Memory Counter Incrementer

This block keeps one counter per item index in an external memory that it reaches only through an AXI4 master port. An index arrives on an input stream. The block reads that index's counter word, adds one, writes the word back, and puts the index and its new count on an output stream. Several of these read-modify-write operations can be in progress at the same time. This includes several operations on the same index, so back-to-back repeats do not stall the input.

Every accepted operation takes a slot in a tracking queue. The slots are kept in arrival order, and each channel (read address, read data, write address, write data, write response, result) walks the queue with its own pointer. When an index arrives that already has an operation in the queue, the new operation does not read memory. It takes its starting value from the newest earlier operation on that index, forwarded inside the block. A slot is released only after its write response has come back and its result has left the block.

Top module: `axi_cnt_incr`

## Requirements
- R1: While reset is held and in the cycle after it is released, `idle` and `in_ready` are 1, and `out_valid`, `m_arvalid`, `m_awvalid`, `m_wvalid`, `m_rready` and `m_bready` are 0.
- R2: Each accepted index gives exactly one result. Results leave in the order their indexes were accepted. Each result carries its index and a count equal to the number of times that index has been accepted since the memory was zero, including this time.
- R3: Once all operations have finished, the memory word for every index equals the total number of times that index was accepted.
- R4: Read and write addresses equal index × (DATA_W/8). Every write has all byte strobes set, and its data equals the word's previous value plus one.
- R5: An index that arrives while an earlier operation on the same index is still in the queue issues no read. Four back-to-back copies of one index therefore cause exactly one read.
- R6: Once `m_arvalid`, `m_awvalid`, `m_wvalid` or `out_valid` is raised, it stays high with an unchanged payload until the matching ready is seen.
- R7: At most DEPTH operations are in flight. With DEPTH outstanding, `in_ready` is 0.
- R8: `idle` is 1 exactly when no operation is in flight. In that state every read address has had its read data and every write has had its response. No channel valid or ready output is high.
- R9: R2 and R3 still hold when every AXI channel and both streams stall at random.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Index offered |
| in_ready | output | 1 | Index accepted when both high |
| in_idx | input | IDX_W | Item index |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Result taken when both high |
| out_idx | output | IDX_W | Index of the result |
| out_count | output | DATA_W | Count after this increment |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | ADDR_W | Read byte address |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | DATA_W | Read data |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Write byte address |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte strobes |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| idle | output | 1 | No operation in flight |

## Verification
- **Read-address timing:** the read address for an accepted index is driven in the cycle after acceptance.
- **Result and write timing:** the result, write address and write data follow one cycle after the read data is taken. For a forwarded operation they follow one cycle after its predecessor's value is known.
- **Write-response timing:** the write response is accepted only once the slot's address and data have both been sent.
- **How the checks follow this:** these latencies move with the stalls, so the checks are tied to handshakes rather than fixed cycle counts. The bench samples at the falling edge the transfer that the next rising edge will commit, and compares results in order against counts it keeps itself. The reset state is checked one step after the first rising edge without reset. Forwarding and the occupancy limit are checked with memory latency stretched or read addresses held off.

// File: rtl/incr_pkg.sv
package incr_pkg;

    localparam int DEF_IDX_W  = 4;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_DEPTH  = 4;

    // Per-slot status of the tracking queue
    typedef struct packed {
        logic vld;      // slot holds an operation
        logic dep;      // value comes from an older slot, no memory read
        logic has_val;  // incremented count is known
        logic b_done;   // write response received
    } slot_flags_t;

    function automatic int addr_shift(int data_w);
        return $clog2(data_w / 8);
    endfunction

endpackage

// File: rtl/incr_ptr.sv
module incr_ptr #(
    parameter int PW = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        adv,
    output logic [PW:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)      ptr <= '0;
        else if (adv) ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/incr_match.sv
module incr_match #(
    parameter  int IDX_W = 4,
    parameter  int DEPTH = 4,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic             vld [DEPTH],
    input  logic [IDX_W-1:0] idx [DEPTH],
    input  logic [PW-1:0]    head,
    input  logic [IDX_W-1:0] key,
    output logic             hit,
    output logic [PW-1:0]    slot
);
    logic [PW-1:0] s;

    // Walk from oldest to newest; the last match is the newest one
    always_comb begin
        hit  = 1'b0;
        slot = '0;
        s    = '0;
        for (int k = 0; k < DEPTH; k++) begin
            s = head + PW'(k);
            if (vld[s] && idx[s] == key) begin
                hit  = 1'b1;
                slot = s;
            end
        end
    end
endmodule

// File: rtl/incr_slot.sv
module incr_slot
    import incr_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int CNT_W = 32,
    parameter int PW    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  logic [IDX_W-1:0] a_idx,
    input  logic             a_dep,
    input  logic [PW-1:0]    a_pred,
    input  logic             a_known,
    input  logic [CNT_W-1:0] a_val,
    input  logic             rd_load,
    input  logic [CNT_W-1:0] rd_word,
    input  logic             pred_known,
    input  logic [CNT_W-1:0] pred_val,
    input  logic             ack_set,
    input  logic             free,
    output slot_flags_t      flags,
    output logic [IDX_W-1:0] idx,
    output logic [PW-1:0]    pred,
    output logic [CNT_W-1:0] val
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            idx   <= '0;
            pred  <= '0;
            val   <= '0;
        end else if (free) begin
            flags <= '0;
        end else if (alloc) begin
            flags <= '{vld: 1'b1, dep: a_dep, has_val: a_known, b_done: 1'b0};
            idx   <= a_idx;
            pred  <= a_pred;
            val   <= a_val;
        end else begin
            if (rd_load) begin
                flags.has_val <= 1'b1;
                val           <= rd_word + 1'b1;
            end else if (flags.vld && flags.dep && !flags.has_val && pred_known) begin
                // forwarding from the older slot on the same index
                flags.has_val <= 1'b1;
                val           <= pred_val + 1'b1;
            end
            if (ack_set) flags.b_done <= 1'b1;
        end
    end
endmodule

// File: rtl/axi_cnt_incr.sv
module axi_cnt_incr
    import incr_pkg::*;
#(
    parameter  int IDX_W   = DEF_IDX_W,
    parameter  int DATA_W  = DEF_DATA_W,
    parameter  int ADDR_W  = 32,
    parameter  int DEPTH   = DEF_DEPTH,
    localparam int PW      = $clog2(DEPTH),
    localparam int BYTE_SH = addr_shift(DATA_W),
    localparam int STRB_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IDX_W-1:0]  in_idx,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [IDX_W-1:0]  out_idx,
    output logic [DATA_W-1:0] out_count,
    output logic              m_arvalid,
    input  logic              m_arready,
    output logic [ADDR_W-1:0] m_araddr,
    input  logic              m_rvalid,
    output logic              m_rready,
    input  logic [DATA_W-1:0] m_rdata,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [ADDR_W-1:0] m_awaddr,
    output logic              m_wvalid,
    input  logic              m_wready,
    output logic [DATA_W-1:0] m_wdata,
    output logic [STRB_W-1:0] m_wstrb,
    input  logic              m_bvalid,
    output logic              m_bready,
    output logic              idle
);
    // Queue pointers, one extra wrap bit each
    logic [PW:0] tail, head, ar_p, r_p, aw_p, w_p, o_p;
    logic adv_tail, adv_head, adv_ar, adv_r, adv_aw, adv_w, adv_o;

    slot_flags_t       fl    [DEPTH];
    logic              s_vld [DEPTH];
    logic [IDX_W-1:0]  s_idx [DEPTH];
    logic [PW-1:0]     s_pred[DEPTH];
    logic [DATA_W-1:0] s_val [DEPTH];

    logic              hit;
    logic [PW-1:0]     hit_slot;
    logic              fwd_known;
    logic [DATA_W-1:0] fwd_val;

    logic full, accept, r_hs, b_hs, retire;
    logic ar_pend, r_pend, aw_pend, w_pend, o_pend, h_pend;
    slot_flags_t ar_f, r_f, aw_f, w_f, o_f, h_f;

    incr_ptr #(.PW(PW)) u_tail (.clk(clk), .rst(rst), .adv(adv_tail), .ptr(tail));
    incr_ptr #(.PW(PW)) u_head (.clk(clk), .rst(rst), .adv(adv_head), .ptr(head));
    incr_ptr #(.PW(PW)) u_ar   (.clk(clk), .rst(rst), .adv(adv_ar),   .ptr(ar_p));
    incr_ptr #(.PW(PW)) u_r    (.clk(clk), .rst(rst), .adv(adv_r),    .ptr(r_p));
    incr_ptr #(.PW(PW)) u_aw   (.clk(clk), .rst(rst), .adv(adv_aw),   .ptr(aw_p));
    incr_ptr #(.PW(PW)) u_w    (.clk(clk), .rst(rst), .adv(adv_w),    .ptr(w_p));
    incr_ptr #(.PW(PW)) u_o    (.clk(clk), .rst(rst), .adv(adv_o),    .ptr(o_p));

    incr_match #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_match (
        .vld (s_vld),
        .idx (s_idx),
        .head(head[PW-1:0]),
        .key (in_idx),
        .hit (hit),
        .slot(hit_slot)
    );

    always_comb begin
        full   = (tail[PW] != head[PW]) && (tail[PW-1:0] == head[PW-1:0]);
        idle   = (tail == head);
        ar_pend = (ar_p != tail);
        r_pend  = (r_p  != tail);
        aw_pend = (aw_p != tail);
        w_pend  = (w_p  != tail);
        o_pend  = (o_p  != tail);
        h_pend  = (head != tail);
        ar_f = fl[ar_p[PW-1:0]];
        r_f  = fl[r_p[PW-1:0]];
        aw_f = fl[aw_p[PW-1:0]];
        w_f  = fl[w_p[PW-1:0]];
        o_f  = fl[o_p[PW-1:0]];
        h_f  = fl[head[PW-1:0]];

        in_ready = !full;
        accept   = in_valid && in_ready;
        fwd_known = hit && fl[hit_slot].has_val;
        fwd_val   = fwd_known ? s_val[hit_slot] + 1'b1 : '0;

        // read address: forwarded slots are skipped
        m_arvalid = ar_pend && !ar_f.dep;
        m_araddr  = ADDR_W'(s_idx[ar_p[PW-1:0]]) << BYTE_SH;
        adv_ar    = ar_pend && (ar_f.dep || m_arready);

        // read data: only after that slot's address went out
        m_rready = r_pend && !r_f.dep && (r_p != ar_p);
        r_hs     = m_rready && m_rvalid;
        adv_r    = r_pend && (r_f.dep || m_rvalid) && (r_f.dep || m_rready);

        m_awvalid = aw_pend && aw_f.has_val;
        m_awaddr  = ADDR_W'(s_idx[aw_p[PW-1:0]]) << BYTE_SH;
        adv_aw    = m_awvalid && m_awready;

        m_wvalid = w_pend && w_f.has_val;
        m_wdata  = s_val[w_p[PW-1:0]];
        m_wstrb  = '1;
        adv_w    = m_wvalid && m_wready;

        out_valid = o_pend && o_f.has_val;
        out_idx   = s_idx[o_p[PW-1:0]];
        out_count = s_val[o_p[PW-1:0]];
        adv_o     = out_valid && out_ready;

        // responses return in order, so the head owns the next one
        m_bready = h_pend && (aw_p != head) && (w_p != head) && !h_f.b_done;
        b_hs     = m_bready && m_bvalid;
        retire   = h_pend && h_f.b_done && (o_p != head);

        adv_tail = accept;
        adv_head = retire;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam logic [PW-1:0] SLOT_ID = PW'(g);
        incr_slot #(.IDX_W(IDX_W), .CNT_W(DATA_W), .PW(PW)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .alloc     (accept && (tail[PW-1:0] == SLOT_ID)),
            .a_idx     (in_idx),
            .a_dep     (hit),
            .a_pred    (hit_slot),
            .a_known   (fwd_known),
            .a_val     (fwd_val),
            .rd_load   (r_hs && (r_p[PW-1:0] == SLOT_ID)),
            .rd_word   (m_rdata),
            .pred_known(fl[s_pred[g]].has_val),
            .pred_val  (s_val[s_pred[g]]),
            .ack_set   (b_hs && (head[PW-1:0] == SLOT_ID)),
            .free      (retire && (head[PW-1:0] == SLOT_ID)),
            .flags     (fl[g]),
            .idx       (s_idx[g]),
            .pred      (s_pred[g]),
            .val       (s_val[g])
        );
        assign s_vld[g] = fl[g].vld;
    end
endmodule

// File: rtl/axi_cnt_incr_chk.sv
module axi_cnt_incr_chk #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              idle,
    input logic              out_valid,
    input logic              out_ready,
    input logic [IDX_W-1:0]  out_idx,
    input logic [DATA_W-1:0] out_count,
    input logic              m_arvalid,
    input logic              m_arready,
    input logic [ADDR_W-1:0] m_araddr,
    input logic              m_awvalid,
    input logic              m_awready,
    input logic [ADDR_W-1:0] m_awaddr,
    input logic              m_wvalid,
    input logic              m_wready,
    input logic [DATA_W-1:0] m_wdata,
    input logic              m_rready,
    input logic              m_bready
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> idle && in_ready && !out_valid);

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_idx) && $stable(out_count));

    // R6
    ar_hold_chk: assert property (@(posedge clk) disable iff (rst)
        m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr));

    // R6
    aw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));

    // R6
    w_hold_chk: assert property (@(posedge clk) disable iff (rst)
        m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata));

    // R7
    full_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> !idle);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        idle |-> !m_arvalid && !m_awvalid && !m_wvalid && !out_valid && !m_rready && !m_bready);
endmodule

bind axi_cnt_incr axi_cnt_incr_chk #(
    .IDX_W (IDX_W),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) chk_i (.*);

// File: tb/axi_cnt_incr_tb_top.sv
`timescale 1ns/100ps
module axi_cnt_incr_tb_top;
    localparam int IDX_W  = 4;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int DEPTH  = 4;
    localparam int NIDX   = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_ready;
    logic [IDX_W-1:0] in_idx = '0;
    logic out_valid, out_ready = 1'b0;
    logic [IDX_W-1:0] out_idx;
    logic [DATA_W-1:0] out_count;
    logic m_arvalid, m_arready = 1'b0;
    logic [ADDR_W-1:0] m_araddr;
    logic m_rvalid = 1'b0, m_rready;
    logic [DATA_W-1:0] m_rdata = '0;
    logic m_awvalid, m_awready = 1'b0;
    logic [ADDR_W-1:0] m_awaddr;
    logic m_wvalid, m_wready = 1'b0;
    logic [DATA_W-1:0] m_wdata;
    logic [DATA_W/8-1:0] m_wstrb;
    logic m_bvalid = 1'b0, m_bready;
    logic idle;

    always #2.5 clk = ~clk;

    axi_cnt_incr #(.IDX_W(IDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut_i (.*);

    int errors = 0;
    int checks = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // memory model and stream state
    logic [DATA_W-1:0] mem [NIDX];
    int stall_pct = 0;
    int rd_lat = 1;
    bit ar_block = 1'b0;
    int ar_cnt = 0, r_cnt = 0, aw_cnt = 0, w_cnt = 0, b_cnt = 0, acc_cnt = 0;
    int cyc = 0;
    int rq_idx[$];
    int rq_time[$];
    int awq[$];
    logic [DATA_W-1:0] wq[$];
    int bq_time[$];
    bit r_taken = 0, b_taken = 0, in_taken = 0;
    bit ar_hold = 0, out_hold = 0;
    logic [ADDR_W-1:0] ar_held;
    logic [DATA_W-1:0] out_held;
    int ref_cnt [NIDX];
    int exp_idx[$];
    int exp_cnt[$];
    int in_list[$];

    function automatic bit go();
        return $urandom_range(99) >= stall_pct;
    endfunction

    // Runs at each falling edge: sets the bench's drives and books the transfers
    // that the next rising edge commits.
    task automatic model_step();
        cyc++;
        if (rst) return;
        // R6 hold checks for the previous stalled cycle
        if (ar_hold) chk(m_arvalid && m_araddr == ar_held, "R6", "araddr held", longint'(m_araddr), longint'(ar_held));
        if (out_hold) chk(out_valid && out_count == out_held, "R6", "out_count held", longint'(out_count), longint'(out_held));
        // read data
        if (r_taken) m_rvalid = 1'b0;
        if (!m_rvalid && rq_idx.size() > 0 && rq_time[0] <= cyc && go()) begin
            m_rvalid = 1'b1;
            m_rdata  = mem[rq_idx[0]];
        end
        r_taken = m_rvalid && m_rready;
        if (r_taken) begin
            void'(rq_idx.pop_front());
            void'(rq_time.pop_front());
            r_cnt++;
        end
        // read address
        m_arready = !ar_block && go();
        ar_hold = m_arvalid && !m_arready;
        ar_held = m_araddr;
        if (m_arvalid && m_arready) begin
            chk(m_araddr[1:0] == 2'b00 && (m_araddr >> 2) < NIDX, "R4", "araddr", longint'(m_araddr), 0);
            rq_idx.push_back(int'(m_araddr >> 2));
            rq_time.push_back(cyc + rd_lat);
            ar_cnt++;
        end
        // write address and data
        m_awready = go();
        m_wready  = go();
        if (m_awvalid && m_awready) begin
            chk(m_awaddr[1:0] == 2'b00 && (m_awaddr >> 2) < NIDX, "R4", "awaddr", longint'(m_awaddr), 0);
            awq.push_back(int'(m_awaddr >> 2));
            aw_cnt++;
        end
        if (m_wvalid && m_wready) begin
            chk(m_wstrb == '1, "R4", "wstrb", longint'(m_wstrb), 15);
            wq.push_back(m_wdata);
            w_cnt++;
        end
        while (awq.size() > 0 && wq.size() > 0) begin
            int a;
            logic [DATA_W-1:0] d;
            a = awq.pop_front();
            d = wq.pop_front();
            chk(d == mem[a] + 1, "R4", "write data is old plus one", longint'(d), longint'(mem[a] + 1));
            mem[a] = d;
            bq_time.push_back(cyc + 1);
        end
        // write response
        if (b_taken) m_bvalid = 1'b0;
        if (!m_bvalid && bq_time.size() > 0 && bq_time[0] <= cyc && go()) m_bvalid = 1'b1;
        b_taken = m_bvalid && m_bready;
        if (b_taken) begin
            void'(bq_time.pop_front());
            b_cnt++;
        end
        // result stream
        out_ready = go();
        out_hold = out_valid && !out_ready;
        out_held = out_count;
        if (out_valid && out_ready) begin
            if (exp_idx.size() == 0) begin
                chk(1'b0, "R2", "unexpected result", longint'(out_idx), -1);
            end else begin
                int ei, ec;
                ei = exp_idx.pop_front();
                ec = exp_cnt.pop_front();
                chk(int'(out_idx) == ei, "R2", "out_idx", longint'(out_idx), ei);
                chk(int'(out_count) == ec, "R2", "out_count", longint'(out_count), ec);
            end
        end
        // input stream
        if (in_taken) in_valid = 1'b0;
        if (!in_valid && in_list.size() > 0 && go()) begin
            in_valid = 1'b1;
            in_idx   = IDX_W'(in_list.pop_front());
        end
        in_taken = in_valid && in_ready;
        if (in_taken) begin
            ref_cnt[in_idx]++;
            exp_idx.push_back(int'(in_idx));
            exp_cnt.push_back(ref_cnt[in_idx]);
            acc_cnt++;
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            model_step();
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drain(string tag);
        while (!(in_list.size() == 0 && !in_valid && exp_idx.size() == 0 && idle &&
                 rq_idx.size() == 0 && bq_time.size() == 0 && !m_rvalid && !m_bvalid)) step();
        repeat (3) step();
        chk(idle == 1'b1, "R8", {tag, " idle"}, longint'(idle), 1);
        chk(ar_cnt == r_cnt, "R8", {tag, " reads answered"}, r_cnt, ar_cnt);
        chk(aw_cnt == b_cnt && w_cnt == aw_cnt, "R8", {tag, " writes acked"}, b_cnt, aw_cnt);
        for (int i = 0; i < NIDX; i++)
            chk(int'(mem[i]) == ref_cnt[i], "R3", {tag, " memory word"}, longint'(mem[i]), ref_cnt[i]);
    endtask

    initial begin
        int ar0, acc0;
        for (int i = 0; i < NIDX; i++) begin
            mem[i] = '0;
            ref_cnt[i] = 0;
        end
        repeat (4) step();
        // R1: reset state while held and just after release
        chk(idle && in_ready, "R1", "idle and in_ready in reset", longint'({idle, in_ready}), 3);
        rst = 1'b0;
        step();
        chk(idle == 1'b1, "R1", "idle", longint'(idle), 1);
        chk(in_ready == 1'b1, "R1", "in_ready", longint'(in_ready), 1);
        chk(!out_valid && !m_arvalid, "R1", "out_valid/arvalid", longint'({out_valid, m_arvalid}), 0);
        chk(!m_awvalid && !m_wvalid, "R1", "awvalid/wvalid", longint'({m_awvalid, m_wvalid}), 0);
        chk(!m_rready && !m_bready, "R1", "rready/bready", longint'({m_rready, m_bready}), 0);

        // R2/R4: every index once, then every index with its neighbour and a repeat
        for (int i = 0; i < NIDX; i++) in_list.push_back(i);
        for (int i = 0; i < NIDX; i++) begin
            in_list.push_back(i);
            in_list.push_back((i + 1) % NIDX);
            in_list.push_back(i);
        end
        drain("sweep");

        // R5: four back-to-back copies with slow reads give a single read
        rd_lat = 12;
        ar0 = ar_cnt;
        for (int k = 0; k < 4; k++) in_list.push_back(9);
        drain("repeat");
        chk(ar_cnt - ar0 == 1, "R5", "reads for repeated index", ar_cnt - ar0, 1);
        ar0 = ar_cnt;
        rd_lat = 3;
        in_list.push_back(3); in_list.push_back(3); in_list.push_back(5);
        in_list.push_back(3); in_list.push_back(5);
        drain("mixed");
        chk(ar_cnt - ar0 == 2, "R5", "reads for mixed repeats", ar_cnt - ar0, 2);

        // R7: with read addresses held off, exactly DEPTH operations are taken
        rd_lat = 1;
        ar_block = 1'b1;
        acc0 = acc_cnt;
        for (int k = 0; k < 8; k++) in_list.push_back(k);
        repeat (20) step();
        chk(acc_cnt - acc0 == DEPTH, "R7", "accepted while blocked", acc_cnt - acc0, DEPTH);
        chk(in_ready == 1'b0, "R7", "in_ready when full", longint'(in_ready), 0);
        ar_block = 1'b0;
        drain("full");

        // R9: random stalls on all channels, small index set to force hazards
        stall_pct = 40;
        rd_lat = 2;
        acc0 = acc_cnt;
        for (int k = 0; k < 300; k++) in_list.push_back($urandom_range(3));
        drain("stall small");
        chk(acc_cnt - acc0 == 300, "R9", "all accepted under stalls", acc_cnt - acc0, 300);
        stall_pct = 25;
        for (int k = 0; k < 200; k++) in_list.push_back($urandom_range(NIDX - 1));
        drain("stall wide");
        chk(exp_idx.size() == 0, "R9", "no result missing", exp_idx.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule